// File: doc/BRIEF.md
# Runtime-Selectable Floating-Point Rounder

This block is the last stage of a single-precision floating-point datapath. It takes a result sign, a biased exponent and a significand. The exponent is two bits wider than the format, is read as two's complement, and so may go below one or above the largest finite exponent. The significand is normalised, with a hidden bit, the fraction and three extra low bits. The block rounds the value to the 32-bit format and packs it, under a rounding mode that is picked on every cycle by a 5-bit vector. It reports overflow, underflow and inexact.

A value whose exponent is below one is first shifted right into the subnormal range. Every bit shifted out is folded into a sticky bit. The chosen mode then decides whether the kept magnitude is incremented. A carry out of the significand bumps the exponent. A result that passes the largest finite exponent saturates to either infinity or the largest finite value. The mode and the sign decide which of the two. The packed result and the flags are registered once when `REG_OUT` is 1, which is the default.

Top module: `fp_round_pack`

## Requirements
- R1: The mode vector is decoded by its lowest set bit: bit 0 gives nearest-even, bit 1 gives nearest-ties-away, bit 2 gives toward +infinity, bit 3 gives toward −infinity, and bit 4 or an all-zero vector gives toward zero.
- R2: The low three significand bits are discarded. Bit 2 of these is the half bit and bits 1:0 are sticky. Nearest-ties-away increments when the half bit is set. Nearest-even increments when the half bit is set and either a sticky bit is set or the kept LSB is 1.
- R3: When any discarded bit is set, toward +infinity increments only positive results and toward −infinity increments only negative ones. Toward zero never increments.
- R4: An increment that carries out of the significand leaves the fraction zero and adds one to the exponent. A subnormal that rounds up to 2^23 becomes the smallest normal, with exponent field 1.
- R5: An exponent of 255 or more after rounding is an overflow. Both nearest modes then give infinity of the result's sign. Toward +infinity gives +infinity or the most negative finite value. Toward −infinity gives the largest positive finite value or −infinity. Toward zero gives the largest finite magnitude with the result's sign.
- R6: Overflow never comes with an infinity in toward-zero mode. It never comes with −infinity in toward-+infinity mode, and never with +infinity in toward-−infinity mode.
- R7: Inexact is 1 when any discarded bit, sticky included, is nonzero, or when there is an overflow.
- R8: Underflow is 1 exactly when the result is not an overflow, its exponent field (bits 30:23) is zero, and it is inexact. It therefore always comes with inexact.
- R9: An input exponent below one shifts the significand right by 1 minus the exponent. All shifted-out bits are ORed into bit 0, and the exponent field becomes 0.
- R10: A zero significand gives a zero of the input sign with all flags clear, whatever the exponent.
- R11: With `REG_OUT`=1 the outputs follow the inputs by one clock, and reset clears the result and flags to zero. The result layout is sign in bit 31, exponent in bits 30:23 and fraction in bits 22:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the optional output register |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sign_i | input | 1 | Result sign |
| exp_i | input | 10 | Biased exponent, two's complement, with headroom |
| sig_i | input | 27 | Significand: hidden bit 26, fraction 25:3, extra bits 2:0 |
| mode_i | input | 5 | Rounding-mode vector, decoded by lowest set bit |
| res_o | output | 32 | Packed single-precision result |
| of_o | output | 1 | Overflow |
| uf_o | output | 1 | Underflow |
| nx_o | output | 1 | Inexact |

## Verification
Mid-range exponents are run with each one-hot mode, both signs, and discarded-bit patterns of exact, below half, exact tie and above half, with the kept LSB both even and odd. Together these tell every mode's increment rule apart from every other's. Vectors with more than one bit set, and an all-zero vector, show that decoding follows the lowest set bit. Inputs at the top exponent tell the five saturation values apart for each sign. A tie on the smallest subnormal and a subnormal that rounds up into the normal range exercise the shifter and the exponent fix-up. A long stretch of random exponents, significands and mode vectors covers the regions in between.

// File: rtl/fpr_pkg.sv
package fpr_pkg;
  typedef enum logic [2:0] {
    RM_NEAR_EVEN,
    RM_NEAR_AWAY,
    RM_UP,
    RM_DOWN,
    RM_ZERO
  } rmode_e;
endpackage

// File: rtl/fpr_mode_dec.sv
module fpr_mode_dec
  import fpr_pkg::*;
(
  input  logic [4:0] vec_i,
  output rmode_e     mode_o
);
  // lowest set bit wins; empty vector truncates
  always_comb begin
    if (vec_i[0])      mode_o = RM_NEAR_EVEN;
    else if (vec_i[1]) mode_o = RM_NEAR_AWAY;
    else if (vec_i[2]) mode_o = RM_UP;
    else if (vec_i[3]) mode_o = RM_DOWN;
    else               mode_o = RM_ZERO;
  end
endmodule

// File: rtl/fpr_denorm.sv
module fpr_denorm #(
  parameter int EXP_W = 8,
  parameter int SIG_W = 27
) (
  input  logic [EXP_W+1:0] exp_i,
  input  logic [SIG_W-1:0] sig_i,
  output logic [EXP_W+1:0] exp_o,
  output logic [SIG_W-1:0] sig_o
);
  localparam int SH_W = $clog2(SIG_W) + 1;

  logic              tiny;
  logic signed [EXP_W+2:0] amt;
  logic [SH_W-1:0]   shc;
  logic [2*SIG_W-1:0] wide;

  assign tiny = exp_i[EXP_W+1] || (exp_i == '0);

  always_comb begin
    amt  = (EXP_W+3)'(1) - {exp_i[EXP_W+1], exp_i};
    shc  = (amt > SIG_W) ? SH_W'(SIG_W) : amt[SH_W-1:0];
    wide = {sig_i, {SIG_W{1'b0}}} >> shc;
    if (tiny) begin
      sig_o = wide[2*SIG_W-1:SIG_W] | {{(SIG_W-1){1'b0}}, |wide[SIG_W-1:0]};
      exp_o = '0;
    end else begin
      sig_o = sig_i;
      exp_o = exp_i;
    end
  end
endmodule

// File: rtl/fpr_round_core.sv
module fpr_round_core
  import fpr_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  parameter int EXT_W = 3
) (
  input  logic                   sign_i,
  input  logic [EXP_W+1:0]       exp_i,
  input  logic [MAN_W+EXT_W:0]   sig_i,
  input  rmode_e                 mode_i,
  output logic [EXP_W+MAN_W:0]   res_o,
  output logic                   of_o,
  output logic                   uf_o,
  output logic                   nx_o
);
  localparam int EXP_MAX = (1 << EXP_W) - 1;

  logic [MAN_W:0]   kept;
  logic [EXT_W-1:0] rbits;
  logic             half, rest, lost, inc, sat_inf, zero;
  logic [MAN_W+1:0] sum;
  logic [MAN_W-1:0] frac;
  logic [EXP_W+1:0] e_fin;
  logic             ovf;

  assign kept  = sig_i[MAN_W+EXT_W:EXT_W];
  assign rbits = sig_i[EXT_W-1:0];
  assign half  = rbits[EXT_W-1];
  assign rest  = |rbits[EXT_W-2:0];
  assign lost  = |rbits;
  assign zero  = (sig_i == '0);

  always_comb begin
    unique case (mode_i)
      RM_NEAR_EVEN: inc = half & (rest | kept[0]);
      RM_NEAR_AWAY: inc = half;
      RM_UP:        inc = lost & ~sign_i;
      RM_DOWN:      inc = lost & sign_i;
      default:      inc = 1'b0;
    endcase
  end

  assign sum = {1'b0, kept} + (MAN_W+2)'(inc);

  always_comb begin
    if (sum[MAN_W+1]) begin
      frac  = sum[MAN_W:1];
      e_fin = exp_i + (EXP_W+2)'(1);
    end else begin
      frac  = sum[MAN_W-1:0];
      // subnormal promoted to normal when hidden bit appears
      e_fin = (exp_i == '0) ? {{(EXP_W+1){1'b0}}, sum[MAN_W]} : exp_i;
    end
  end

  assign ovf = ~zero && (e_fin >= (EXP_W+2)'(EXP_MAX));

  always_comb begin
    unique case (mode_i)
      RM_NEAR_EVEN, RM_NEAR_AWAY: sat_inf = 1'b1;
      RM_UP:                      sat_inf = ~sign_i;
      RM_DOWN:                    sat_inf = sign_i;
      default:                    sat_inf = 1'b0;
    endcase
  end

  always_comb begin
    if (zero) begin
      res_o = {sign_i, {(EXP_W+MAN_W){1'b0}}};
      of_o  = 1'b0;
      uf_o  = 1'b0;
      nx_o  = 1'b0;
    end else if (ovf) begin
      res_o = sat_inf ? {sign_i, {EXP_W{1'b1}}, {MAN_W{1'b0}}}
                      : {sign_i, EXP_W'(EXP_MAX - 1), {MAN_W{1'b1}}};
      of_o  = 1'b1;
      uf_o  = 1'b0;
      nx_o  = 1'b1;
    end else begin
      res_o = {sign_i, e_fin[EXP_W-1:0], frac};
      of_o  = 1'b0;
      uf_o  = lost && (e_fin == '0);
      nx_o  = lost;
    end
  end
endmodule

// File: rtl/fpr_out_stage.sv
module fpr_out_stage #(
  parameter int W       = 35,
  parameter bit REG_OUT = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q_o <= '0;
        else         q_o <= d_i;
      end
    end else begin : g_pass
      assign q_o = d_i;
    end
  endgenerate
endmodule

// File: rtl/fp_round_pack.sv
module fp_round_pack
  import fpr_pkg::*;
#(
  parameter int EXP_W   = 8,
  parameter int MAN_W   = 23,
  parameter int EXT_W   = 3,
  parameter bit REG_OUT = 1'b1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     sign_i,
  input  logic [EXP_W+1:0]         exp_i,
  input  logic [MAN_W+EXT_W:0]     sig_i,
  input  logic [4:0]               mode_i,
  output logic [EXP_W+MAN_W:0]     res_o,
  output logic                     of_o,
  output logic                     uf_o,
  output logic                     nx_o
);
  localparam int SIG_W = MAN_W + EXT_W + 1;
  localparam int RES_W = EXP_W + MAN_W + 1;

  rmode_e           mode;
  logic [EXP_W+1:0] dn_exp;
  logic [SIG_W-1:0] dn_sig;
  logic [RES_W-1:0] core_res;
  logic             core_of, core_uf, core_nx;

  fpr_mode_dec u_dec (
    .vec_i (mode_i),
    .mode_o(mode)
  );

  fpr_denorm #(.EXP_W(EXP_W), .SIG_W(SIG_W)) u_dn (
    .exp_i(exp_i),
    .sig_i(sig_i),
    .exp_o(dn_exp),
    .sig_o(dn_sig)
  );

  fpr_round_core #(.EXP_W(EXP_W), .MAN_W(MAN_W), .EXT_W(EXT_W)) u_core (
    .sign_i(sign_i),
    .exp_i (dn_exp),
    .sig_i (dn_sig),
    .mode_i(mode),
    .res_o (core_res),
    .of_o  (core_of),
    .uf_o  (core_uf),
    .nx_o  (core_nx)
  );

  fpr_out_stage #(.W(RES_W + 3), .REG_OUT(REG_OUT)) u_out (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({core_res, core_of, core_uf, core_nx}),
    .q_o   ({res_o, of_o, uf_o, nx_o})
  );
endmodule

// File: rtl/fpr_chk.sv
module fpr_chk #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [4:0]           mode_i,
  input logic [EXP_W+MAN_W:0] res_i,
  input logic                 of_i,
  input logic                 uf_i,
  input logic                 nx_i
);
  logic near_m, up_m, down_m, zero_m, is_inf, pos_inf, neg_inf;

  assign near_m  = mode_i[0] || (mode_i[1:0] == 2'b10);
  assign up_m    = (mode_i[2:0] == 3'b100);
  assign down_m  = (mode_i[3:0] == 4'b1000);
  assign zero_m  = (mode_i[3:0] == 4'b0000);
  assign is_inf  = (res_i[EXP_W+MAN_W-1:MAN_W] == '1) && (res_i[MAN_W-1:0] == '0);
  assign pos_inf = is_inf && !res_i[EXP_W+MAN_W];
  assign neg_inf = is_inf && res_i[EXP_W+MAN_W];

  // R8
  uf_nx_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) uf_i |-> nx_i);
  // R8
  uf_tiny_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uf_i |-> (res_i[EXP_W+MAN_W-1:MAN_W] == '0));
  // R7
  of_nx_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) of_i |-> nx_i);
  // R5
  near_inf_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (of_i && near_m) |-> is_inf);
  // R6
  rtz_no_inf_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (of_i && zero_m) |-> !is_inf);
  // R6
  rtp_far_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (of_i && up_m) |-> !neg_inf);
  // R6
  rtn_far_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (of_i && down_m) |-> !pos_inf);
endmodule

bind fp_round_pack fpr_chk #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_chk (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .mode_i(mode_i),
  .res_i (core_res),
  .of_i  (core_of),
  .uf_i  (core_uf),
  .nx_i  (core_nx)
);

// File: tb/fp_round_pack_tb.sv
module fp_round_pack_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sign_i = 1'b0;
  logic [9:0]  exp_i = '0;
  logic [26:0] sig_i = '0;
  logic [4:0]  mode_i = '0;
  logic [31:0] res_o;
  logic        of_o, uf_o, nx_o;

  int checks = 0;
  int failures = 0;
  logic [34:0] exp_q[$];
  string       tag_q[$];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  fp_round_pack u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .sign_i(sign_i), .exp_i(exp_i),
    .sig_i(sig_i), .mode_i(mode_i), .res_o(res_o), .of_o(of_o),
    .uf_o(uf_o), .nx_o(nx_o)
  );

  // reference: {res, of, uf, nx}
  function automatic logic [34:0] ref_round(logic s, int e_in, longint sig, logic [4:0] mv);
    longint m, q, r;
    int e, md, sh;
    logic st, up, ovf, nx, uf;
    logic [31:0] res;
    if (sig == 0) return {s, 31'd0, 3'b000};
    e = e_in; m = sig; st = 1'b0;
    if (e < 1) begin
      sh = 1 - e;
      if (sh > 40) begin st = (m != 0); m = 0; end
      else for (int i = 0; i < sh; i++) begin st |= m[0]; m = m >> 1; end
      if (st) m = m | 1;
      e = 0;
    end
    q = m >> 3; r = m & 7;
    if (mv[0]) md = 0; else if (mv[1]) md = 1; else if (mv[2]) md = 2;
    else if (mv[3]) md = 3; else md = 4;
    case (md)
      0: up = (r > 4) || (r == 4 && q[0]);
      1: up = (r >= 4);
      2: up = (r != 0) && !s;
      3: up = (r != 0) && s;
      default: up = 1'b0;
    endcase
    q = q + longint'(up);
    if (e == 0) begin
      if (q >= (64'd1 << 23)) e = 1;
    end else if (q >= (64'd1 << 24)) begin
      q = q >> 1; e = e + 1;
    end
    ovf = (e >= 255);
    if (ovf) begin
      logic to_inf;
      to_inf = (md <= 1) || (md == 2 && !s) || (md == 3 && s);
      res = to_inf ? {s, 8'hff, 23'd0} : {s, 8'hfe, 23'h7fffff};
      nx = 1'b1; uf = 1'b0;
    end else begin
      res = {s, 8'(e), 23'(q)};
      nx = (r != 0); uf = nx && (e == 0);
    end
    return {res, ovf, uf, nx};
  endfunction

  task automatic check(string tag, logic [34:0] act, logic [34:0] expv);
    checks++;
    if (act !== expv) begin
      failures++;
      $display("FAIL %s act=%h expv=%h", tag, act, expv);
    end
  endtask

  task automatic apply(logic s, int e, longint sig, logic [4:0] mv, string tag);
    @(negedge clk_i);
    sign_i = s; exp_i = 10'(e); sig_i = 27'(sig); mode_i = mv;
    exp_q.push_back(ref_round(s, e, sig, mv));
    tag_q.push_back(tag);
  endtask

  // compare one clock after capture (R11 latency)
  always @(posedge clk_i) begin
    #1;
    if (rst_ni && exp_q.size() > 0) begin
      logic [34:0] ev;
      string t;
      ev = exp_q.pop_front();
      t = tag_q.pop_front();
      check(t, {res_o, of_o, uf_o, nx_o}, ev);
    end
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    failures++;
    $display("FAIL watchdog act=running expv=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    longint base;
    repeat (3) @(negedge clk_i);
    check("R11 reset", {res_o, of_o, uf_o, nx_o}, 35'd0);
    sign_i = 1'b1; exp_i = 10'd100; sig_i = 27'h7ffffff; mode_i = 5'b00001;
    @(negedge clk_i);
    check("R11 reset hold", {res_o, of_o, uf_o, nx_o}, 35'd0);
    rst_ni = 1'b1;

    // R2 / R3: each mode, sign, lsb and discarded pattern
    for (int k = 0; k < 5; k++)
      for (int s = 0; s < 2; s++)
        for (int l = 0; l < 2; l++)
          for (int g = 0; g < 8; g++) begin
            base = (64'd1 << 26) | (64'h12345 << 4) | (longint'(l) << 3) | longint'(g);
            apply(s[0], 127, base, 5'(1 << k), (k < 2) ? "R2 nearest" : "R3 directed");
          end

    // R1: multi-bit and empty vectors
    apply(1'b0, 127, (64'd1 << 26) | 64'd12, 5'b11010, "R1 lowest bit away");
    apply(1'b0, 127, (64'd1 << 26) | 64'd5,  5'b11100, "R1 lowest bit up");
    apply(1'b1, 127, (64'd1 << 26) | 64'd5,  5'b11000, "R1 lowest bit down");
    apply(1'b0, 127, (64'd1 << 26) | 64'd7,  5'b00000, "R1 empty truncates");
    apply(1'b1, 127, (64'd1 << 26) | 64'd7,  5'b10000, "R1 zero mode");

    // R4: carry renormalise
    apply(1'b0, 100, 64'h7fffffc, 5'b00001, "R4 carry even");
    apply(1'b1, 100, 64'h7ffffff, 5'b01000, "R4 carry down");
    // R4: subnormal rounds to smallest normal
    apply(1'b0, 0, 64'h7ffffff, 5'b00001, "R4 sub to normal");
    apply(1'b0, 0, 64'h7ffffff, 5'b10000, "R4 sub stays");

    // R5 / R6: largest finite boundary per mode and sign
    for (int k = 0; k < 5; k++)
      for (int s = 0; s < 2; s++) begin
        apply(s[0], 254, 64'h7fffffc, 5'(1 << k), "R5 tie at max");
        apply(s[0], 254, 64'h7fffff9, 5'(1 << k), "R6 sticky at max");
        apply(s[0], 256, 64'h4000000, 5'(1 << k), "R5 exp above");
      end
    apply(1'b0, 254, 64'h7fffff8, 5'b00001, "R7 exact max");
    apply(1'b1, 255, 64'h4000000, 5'b10000, "R7 overflow inexact");

    // R9 / R8: smallest subnormal and ties around it
    apply(1'b0, -22, 64'h4000000, 5'b00001, "R9 smallest subnormal");
    apply(1'b0, -23, 64'h4000000, 5'b00001, "R8 tie to zero");
    apply(1'b1, -23, 64'h4000000, 5'b00010, "R8 tie away");
    apply(1'b0, -23, 64'h4000001, 5'b00001, "R9 sticky above tie");
    apply(1'b1, -200, 64'h4000000, 5'b01000, "R9 far below");
    apply(1'b0, -200, 64'h4000000, 5'b00001, "R8 flush");

    // R10: zero significand
    apply(1'b1, 300, 64'd0, 5'b00100, "R10 zero neg");
    apply(1'b0, -5, 64'd0, 5'b00001, "R10 zero pos");

    // R7: random sweep
    for (int n = 0; n < 3000; n++) begin
      int e;
      longint sg;
      e = int'($urandom_range(0, 300)) - 35;
      sg = (64'd1 << 26) | longint'($urandom_range(0, 32'h3ffffff));
      apply(1'($urandom), e, sg, 5'($urandom), "R7 random");
    end

    repeat (3) @(negedge clk_i);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule